// File: doc/BRIEF.md
# Accumulator ALU with Status Register

This block is the arithmetic and logic stage of an 8-bit accumulator-style core. It takes the working-register value (`a_i`) and a second operand (`b_i`), which is either a file-register value or an immediate constant. It computes one of sixteen operations and drives the result. It also drives the Carry, Digit Carry and Zero flags the operation produces, together with a 3-bit mask telling the register file which of those flags to update.

The block owns the 8-bit status register. The flags sit in the low three bits, two reset-cause bits sit above them, and three bank-select bits sit at the top. When the instruction's destination is the status register itself (`dst_stat_i`), the result is merged into it. Flag bits stay protected whenever the operation updates any flag, and the reset-cause bits can never be written.

Top module: `stat_alu`

## Requirements
- R1: Opcode 0 (add) gives `res_o = (a_i + b_i) mod 256`. Carry is 1 when the true sum exceeds 255, and the mask `upd_o` is 3'b111. Mask bit 2 is Z, bit 1 is DC and bit 0 is C.
- R2: Opcode 1 (subtract) gives `res_o = (b_i - a_i) mod 256`. Carry reports no-borrow: it is 1 exactly when `b_i >= a_i`. The mask is 3'b111.
- R3: Digit Carry is the carry out of bit 3 for add and the no-borrow out of the low nibble for subtract (`b_i[3:0] >= a_i[3:0]`).
- R4: Z is 1 exactly when the result is 00h. AND (2), OR (3), XOR (4), complement of `b_i` (5), increment of `b_i` (6), decrement of `b_i` (7) and pass-through of `b_i` (12) update Z only (mask 3'b100).
- R5: Rotate left (8) gives `{b_i[6:0], cin_i}` with C taken from `b_i[7]`. Rotate right (9) gives `{cin_i, b_i[7:1]}` with C taken from `b_i[0]`. Both use mask 3'b001.
- R6: Nibble swap of `b_i` (10), move of `a_i` (13), bit-set `b_i | a_i` (14) and bit-clear `b_i & ~a_i` (15) use mask 3'b000. When they do not target the status register, the status register does not change.
- R7: Status layout is: bit 0 C, bit 1 DC, bit 2 Z, bit 3 power-down, bit 4 time-out, bits 7:5 bank select. With `dst_stat_i` high, the result is written into bits 7:5. Result bits 2:0 are written only when the mask is 000. Otherwise those three bits keep their value, except the masked flags, which take the computed flags.
- R8: Bits 4:3 are never changed by any operation. Reset (synchronous, active high) sets the status register to 8'b0001_1000.
- R9: Clear (11) gives result 00h and mask 3'b100. Applied to the status register, it leaves 000uu1uu, where u means unchanged.
- R10: `stat_nxt_o` shows the value the status register takes at the next clock edge, and `stat_q_o` shows its current value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Operation code (see requirements) |
| a_i | input | 8 | Working-register operand |
| b_i | input | 8 | File-register or immediate operand |
| cin_i | input | 1 | Carry input for rotates |
| dst_stat_i | input | 1 | Result is written to the status register |
| res_o | output | 8 | Operation result |
| upd_o | output | 3 | Flag update mask {Z, DC, C} |
| stat_nxt_o | output | 8 | Status value after this operation |
| stat_q_o | output | 8 | Current status register |

## Verification
Random opcodes and operands, with the status register as destination in about one operation in eight, exercise all sixteen operations against bench-computed results and flags. Directed vectors target the nibble and byte carry boundaries (0Fh+01h, FFh+01h) and subtraction with equal and smaller minuends, which separates no-borrow polarity from plain carry. Further directed vectors send rotates with both carry-in values, clear to the status register, and flag-free moves of 00h and FFh to the status register. These distinguish protected flag bits, written bank bits and the unwritable reset-cause bits.

// File: rtl/sa_pkg.sv
package sa_pkg;
    localparam int DW  = 8;
    localparam int NIB = DW / 2;

    // status bit positions (the core decodes these)
    localparam int ST_C   = 0;
    localparam int ST_DC  = 1;
    localparam int ST_Z   = 2;
    localparam int ST_PD  = 3;
    localparam int ST_TO  = 4;
    localparam int ST_BNK = 5;
    localparam int NFLG   = 3;

    localparam logic [DW-1:0] ST_RESET = 8'b0001_1000;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,  OP_SUB  = 4'd1,  OP_AND  = 4'd2,  OP_OR   = 4'd3,
        OP_XOR  = 4'd4,  OP_COMF = 4'd5,  OP_INC  = 4'd6,  OP_DEC  = 4'd7,
        OP_RLF  = 4'd8,  OP_RRF  = 4'd9,  OP_SWAP = 4'd10, OP_CLR  = 4'd11,
        OP_PASS = 4'd12, OP_MOVE = 4'd13, OP_BSET = 4'd14, OP_BCLR = 4'd15
    } alu_op_e;

    typedef struct packed {
        logic z;
        logic dc;
        logic c;
    } flags_t;

    function automatic logic [NFLG-1:0] mask_of(alu_op_e op);
        case (op)
            OP_ADD, OP_SUB:                     mask_of = 3'b111;
            OP_RLF, OP_RRF:                     mask_of = 3'b001;
            OP_SWAP, OP_MOVE, OP_BSET, OP_BCLR: mask_of = 3'b000;
            default:                            mask_of = 3'b100;
        endcase
    endfunction
endpackage

// File: rtl/sa_core.sv
module sa_core
    import sa_pkg::*;
(
    input  alu_op_e       op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          cin,
    output logic [DW-1:0] res,
    output flags_t        fl
);
    logic [DW:0]   sum;
    logic [NIB:0]  nsum;
    logic [DW-1:0] addend;
    logic          cadd;
    logic          rot_c;
    logic          is_rot;

    always_comb begin
        cadd   = (op == OP_SUB);
        addend = cadd ? ~a : a;
        sum    = {1'b0, b} + {1'b0, addend} + {{DW{1'b0}}, cadd};
        nsum   = {1'b0, b[NIB-1:0]} + {1'b0, addend[NIB-1:0]} + {{NIB{1'b0}}, cadd};
        rot_c  = 1'b0;
        is_rot = 1'b0;
        case (op)
            OP_ADD, OP_SUB: res = sum[DW-1:0];
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            OP_COMF: res = ~b;
            OP_INC:  res = b + DW'(1);
            OP_DEC:  res = b - DW'(1);
            OP_RLF: begin
                res = {b[DW-2:0], cin};
                rot_c = b[DW-1];
                is_rot = 1'b1;
            end
            OP_RRF: begin
                res = {cin, b[DW-1:1]};
                rot_c = b[0];
                is_rot = 1'b1;
            end
            OP_SWAP: res = {b[NIB-1:0], b[DW-1:NIB]};
            OP_CLR:  res = '0;
            OP_PASS: res = b;
            OP_MOVE: res = a;
            OP_BSET: res = b | a;
            default: res = b & ~a;
        endcase
        fl.c  = is_rot ? rot_c : sum[DW];
        fl.dc = nsum[NIB];
        fl.z  = (res == '0);
    end
endmodule

// File: rtl/sa_mask.sv
module sa_mask
    import sa_pkg::*;
(
    input  alu_op_e         op,
    output logic [NFLG-1:0] upd
);
    assign upd = mask_of(op);
endmodule

// File: rtl/sa_status.sv
module sa_status
    import sa_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [DW-1:0]   res,
    input  flags_t          fl,
    input  logic [NFLG-1:0] upd,
    input  logic            dst,
    output logic [DW-1:0]   q,
    output logic [DW-1:0]   nxt
);
    logic [NFLG-1:0] flv;
    assign flv = fl;

    always_comb begin
        nxt = q;
        if (dst) begin
            nxt[DW-1:ST_BNK] = res[DW-1:ST_BNK];
            if (upd == '0)
                nxt[NFLG-1:0] = res[NFLG-1:0];
        end
        for (int i = 0; i < NFLG; i++)
            if (upd[i]) nxt[i] = flv[i];
    end

    always_ff @(posedge clk) begin
        if (rst) q <= ST_RESET;
        else     q <= nxt;
    end
endmodule

// File: rtl/stat_alu.sv
module stat_alu
    import sa_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [3:0]      op_i,
    input  logic [DW-1:0]   a_i,
    input  logic [DW-1:0]   b_i,
    input  logic            cin_i,
    input  logic            dst_stat_i,
    output logic [DW-1:0]   res_o,
    output logic [NFLG-1:0] upd_o,
    output logic [DW-1:0]   stat_nxt_o,
    output logic [DW-1:0]   stat_q_o
);
    alu_op_e op;
    flags_t  fl;
    assign op = alu_op_e'(op_i);

    sa_core u_core (.op(op), .a(a_i), .b(b_i), .cin(cin_i), .res(res_o), .fl(fl));
    sa_mask u_mask (.op(op), .upd(upd_o));
    sa_status u_stat (
        .clk(clk), .rst(rst), .res(res_o), .fl(fl), .upd(upd_o),
        .dst(dst_stat_i), .q(stat_q_o), .nxt(stat_nxt_o)
    );
endmodule

// File: rtl/sa_chk.sv
module sa_chk
    import sa_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic [3:0]      op_i,
    input logic [DW-1:0]   a_i,
    input logic [DW-1:0]   b_i,
    input logic            dst_stat_i,
    input logic [DW-1:0]   res_o,
    input logic [NFLG-1:0] upd_o,
    input logic [DW-1:0]   stat_q_o
);
    p_add_result_r1: assert property (@(posedge clk) disable iff (rst)
        (op_i == 4'd0) |-> (res_o == DW'(a_i + b_i)) && (upd_o == 3'b111));

    p_sub_result_r2: assert property (@(posedge clk) disable iff (rst)
        (op_i == 4'd1) |-> (res_o == DW'(b_i - a_i)) && (upd_o == 3'b111));

    p_zero_flag_r4: assert property (@(posedge clk) disable iff (rst)
        upd_o[ST_Z] |=> (stat_q_o[ST_Z] == ($past(res_o) == '0)));

    p_rot_mask_r5: assert property (@(posedge clk) disable iff (rst)
        (op_i == 4'd8 || op_i == 4'd9) |-> (upd_o == 3'b001));

    p_no_flag_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (upd_o == '0 && !dst_stat_i) |=> $stable(stat_q_o));

    p_cause_bits_r8: assert property (@(posedge clk) disable iff (rst)
        stat_q_o[ST_TO] && stat_q_o[ST_PD]);

    p_clr_status_r9: assert property (@(posedge clk) disable iff (rst)
        (op_i == 4'd11 && dst_stat_i) |=>
            (stat_q_o[DW-1:ST_BNK] == '0) && stat_q_o[ST_Z] &&
            (stat_q_o[1:0] == $past(stat_q_o[1:0])));
endmodule

bind stat_alu sa_chk u_chk (
    .clk(clk), .rst(rst), .op_i(op_i), .a_i(a_i), .b_i(b_i),
    .dst_stat_i(dst_stat_i), .res_o(res_o), .upd_o(upd_o), .stat_q_o(stat_q_o)
);

// File: tb/sim_stat_alu.sv
module sim_stat_alu;
    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] op;
    logic [7:0] a, b;
    logic       cin, dst;
    logic [7:0] res, snxt, sq;
    logic [2:0] upd;

    int vecs = 0;
    int errs = 0;
    logic [7:0] mst;

    always #5 clk = ~clk;

    stat_alu u0 (
        .clk(clk), .rst(rst), .op_i(op), .a_i(a), .b_i(b), .cin_i(cin),
        .dst_stat_i(dst), .res_o(res), .upd_o(upd), .stat_nxt_o(snxt), .stat_q_o(sq)
    );

    initial begin
        #2000000;
        errs++;
        $display("FAIL watchdog: act=timeout exp=finish");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    function automatic logic [7:0] m_res(logic [3:0] o, logic [7:0] x, logic [7:0] y, logic ci);
        case (o)
            0: return 8'(int'(x) + int'(y));
            1: return 8'(int'(y) - int'(x));
            2: return x & y;
            3: return x | y;
            4: return x ^ y;
            5: return ~y;
            6: return 8'(int'(y) + 1);
            7: return 8'(int'(y) - 1);
            8: return {y[6:0], ci};
            9: return {ci, y[7:1]};
            10: return {y[3:0], y[7:4]};
            11: return 8'h00;
            12: return y;
            13: return x;
            14: return y | x;
            default: return y & ~x;
        endcase
    endfunction

    function automatic logic [2:0] m_mask(logic [3:0] o);
        if (o <= 1) return 3'b111;
        if (o == 8 || o == 9) return 3'b001;
        if (o == 10 || o >= 13) return 3'b000;
        return 3'b100;
    endfunction

    // {z, dc, c}
    function automatic logic [2:0] m_flags(logic [3:0] o, logic [7:0] x, logic [7:0] y, logic ci);
        logic c, d;
        c = 1'b0; d = 1'b0;
        if (o == 0) begin
            c = (int'(x) + int'(y)) > 255;
            d = (int'(x[3:0]) + int'(y[3:0])) > 15;
        end else if (o == 1) begin
            c = y >= x;
            d = y[3:0] >= x[3:0];
        end else if (o == 8) c = y[7];
        else if (o == 9) c = y[0];
        return {m_res(o, x, y, ci) == 8'h00, d, c};
    endfunction

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic apply(logic [3:0] o, logic [7:0] x, logic [7:0] y, logic ci, logic d, string tag);
        logic [7:0] r, n;
        logic [2:0] m, f;
        @(negedge clk);
        op = o; a = x; b = y; cin = ci; dst = d;
        #1;
        r = m_res(o, x, y, ci);
        m = m_mask(o);
        f = m_flags(o, x, y, ci);
        n = mst;
        if (d) begin
            n[7:5] = r[7:5];
            if (m == 3'b000) n[2:0] = r[2:0];
        end
        for (int i = 0; i < 3; i++) if (m[i]) n[i] = f[i];
        chk({tag, " result"}, res, r);
        chk({tag, " mask R10"}, {5'b0, upd}, {5'b0, m});
        chk({tag, " next status R10"}, snxt, n);
        @(posedge clk);
        #1;
        mst = n;
        chk({tag, " status R7 R8"}, sq, mst);
    endtask

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; op = 4'd13; a = 0; b = 0; cin = 0; dst = 0;
        repeat (3) @(posedge clk);
        #1;
        chk("R11/R8 reset status", sq, 8'b0001_1000);
        @(negedge clk);
        rst = 1'b0;
        mst = 8'b0001_1000;

        apply(4'd0, 8'h01, 8'h0F, 0, 0, "R3 add nibble carry");
        apply(4'd0, 8'h01, 8'hFF, 0, 0, "R1 add wrap zero");
        apply(4'd0, 8'h80, 8'h7F, 0, 0, "R1 add no carry");
        apply(4'd1, 8'h05, 8'h05, 0, 0, "R2 sub equal");
        apply(4'd1, 8'h04, 8'h03, 0, 0, "R2 sub borrow");
        apply(4'd1, 8'h01, 8'h10, 0, 0, "R3 sub nibble borrow");
        apply(4'd8, 8'h00, 8'h80, 1, 0, "R5 rlf");
        apply(4'd9, 8'h00, 8'h01, 0, 0, "R5 rrf");
        apply(4'd2, 8'hF0, 8'h0F, 0, 0, "R4 and zero");
        apply(4'd10, 8'h00, 8'h00, 0, 0, "R6 swap zero");
        apply(4'd13, 8'hFF, 8'h00, 0, 1, "R7 move ff to status");
        apply(4'd0, 8'h00, 8'hE0, 0, 1, "R7 add to status");
        apply(4'd11, 8'h00, 8'h00, 0, 1, "R9 clear status");
        apply(4'd13, 8'h00, 8'h00, 0, 1, "R8 move 00 to status");
        apply(4'd14, 8'h20, 8'h00, 0, 0, "R6 bset no flags");

        for (int k = 0; k < 3000; k++)
            apply(4'($urandom_range(0, 15)), 8'($urandom), 8'($urandom), 1'($urandom),
                  ($urandom_range(0, 7) == 0), "R1-R10 random");

        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule